// File: doc/BRIEF.md
# Data Link Transmit Arbiter

This block decides, bit by bit, what is placed on an outgoing data link channel. Two sources compete for the channel. The first is a message-oriented frame that an external HDLC controller delivers one bit at a time while it holds a frame-valid line high. The second is a 16-bit bit-oriented code word that is built inside the block and sent a programmed number of times. External frames always win. The block surrounds each frame with a long run of opening flags and one closing flag. Code words are sent only while the channel would otherwise carry idle flags. The block does not compute a CRC and does not stuff zero bits into the frame. The external controller does both.

The channel advances one bit on each `bit_en` strobe. `dl_bit` is the bit of the current bit period, and the block moves on at the clock edge where `bit_en` is high. The controller supplies `msg_bit` and sees it consumed on each strobe where `msg_take` is high. It ends the frame by dropping `msg_valid`. Software loads a code word and a repetition mode and pulses `cw_start`. The block then runs the whole sequence without further help and pulses `cw_done` when the sequence ends.

The controller (`dl_tx_arbiter`) has five states:
- `ST_IDLE` sends flags. At each flag byte boundary it moves to `ST_OPEN` if a frame is pending, or to `ST_CW` if a code word sequence is active.
- `ST_OPEN` sends the opening flags and then moves to `ST_MSG`.
- `ST_MSG` passes frame bits through. When `msg_valid` is low it moves to `ST_CLOSE`.
- `ST_CLOSE` finishes the closing flag and returns to `ST_IDLE`.
- `ST_CW` sends code word bits. At each word boundary it returns to `ST_IDLE` if that word was the last one, moves to `ST_OPEN` if a frame is pending, or stays in `ST_CW`.

Top module: `dl_tx_arbiter`

## Requirements
- R1: With no work pending, `dl_bit` carries repeated flag bytes 0x7E, least significant bit first. The bit order on the line is 0,1,1,1,1,1,1,0.
- R2: A frame that is pending at an idle flag byte boundary causes the following sequence:
  - 27 opening flag bytes.
  - The frame bits, in order.
  - Exactly one closing flag byte. Its first bit (0) is sent in the first bit period where `msg_valid` is low during the frame phase.
  - Idle flags after that.
- R3: `msg_take` is high only during the frame phase while `msg_valid` is high. Each strobe with `msg_take` high consumes exactly one `msg_bit`.
- R4: A code word is 16 bits, sent in this order on the line: eight ones, one 0, `cw_code` bit 0 through bit 5, and then a final 0.
- R5: `cw_mode` selects the number of words: 0 sends a single word, 1 sends 10 words, 2 sends 25 words, and 3 repeats the word until stopped. Code and mode are latched on `cw_start`.
- R6: A code word starts only at an idle flag byte boundary. If a frame and a code word sequence are both pending at that boundary, the frame goes first.
- R7: A code word that has begun is always completed. A frame that becomes pending during a word starts its opening flags right after that word. The remaining words resume after the closing flag and one idle flag byte.
- R8: A `cw_stop` pulse during an active sequence makes the current word the last one.
- R9: `cw_done` is a one-clock pulse in the clock after the final bit strobe of the last word of a sequence.
- R10: A `cw_start` pulse while a sequence is active, including while it is suspended by a frame, is ignored. The running code, mode and count are unchanged.
- R11: After reset the block is idle at the start of a flag byte, with `dl_bit`=0, `msg_take`=0 and `cw_done`=0. The state changes only on clocks where `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-clock strobe that ends the current bit period |
| msg_valid | input | 1 | External frame pending or in progress |
| msg_bit | input | 1 | Current external frame bit |
| msg_take | output | 1 | Frame bit is consumed on this strobe |
| cw_code | input | 6 | Six code bits of the bit-oriented word |
| cw_mode | input | 2 | Repetition mode: 0 once, 1 ten, 2 twenty-five, 3 continuous |
| cw_start | input | 1 | Starts a code word sequence |
| cw_stop | input | 1 | Ends the sequence after the current word |
| dl_bit | output | 1 | Data link bit for the current bit period |
| cw_done | output | 1 | Pulse when a code word sequence ends |

## Verification
A wrong state or counter in this block shows up on `dl_bit` within one bit period: the flag, frame or code word pattern slips against the expected stream. A wrong opening count moves every later bit of the frame. The bench therefore compares whole captured bit streams against streams it builds from the requirements. A wrong repetition count or a lost suspended sequence shows as a misplaced or missing `cw_done` pulse, and the bench checks the bit position of each pulse.

// File: rtl/dl_tx_pkg.sv
package dl_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_MSG,
        ST_CLOSE,
        ST_CW
    } dl_state_t;

    typedef enum logic [1:0] {
        RPT_ONCE       = 2'd0,
        RPT_TEN        = 2'd1,
        RPT_TWENTYFIVE = 2'd2,
        RPT_FOREVER    = 2'd3
    } rpt_mode_t;

    localparam logic [7:0] FLAG_BYTE = 8'h7E;

endpackage

// File: rtl/dl_rep_ctr.sv
module dl_rep_ctr #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/dl_cw_ctrl.sv
module dl_cw_ctrl
    import dl_tx_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int REP_A  = 10,
    parameter int REP_B  = 25,
    localparam int WORD_W = CODE_W + 10,
    localparam int CNT_W  = $clog2((REP_A > REP_B ? REP_A : REP_B) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [1:0]        mode,
    input  logic [CODE_W-1:0] code,
    input  logic              word_end,
    output logic              active,
    output logic              last,
    output logic              done,
    output logic [WORD_W-1:0] cw_vec
);

    logic [CODE_W-1:0] code_q;
    rpt_mode_t         mode_q;
    logic              stop_q;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  limit;
    logic              accept;

    assign accept = start && !active;

    dl_rep_ctr #(.CNT_W(CNT_W)) u_rep (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (word_end && mode_q != RPT_FOREVER),
        .count (count)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            stop_q <= 1'b0;
            done   <= 1'b0;
            code_q <= '0;
            mode_q <= RPT_ONCE;
        end else begin
            done <= 1'b0;
            if (accept) begin
                active <= 1'b1;
                stop_q <= 1'b0;
                code_q <= code;
                mode_q <= rpt_mode_t'(mode);
            end else if (active) begin
                if (word_end && last) begin
                    active <= 1'b0;
                    stop_q <= 1'b0;
                    done   <= 1'b1;
                end else if (stop) begin
                    stop_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        unique case (mode_q)
            RPT_ONCE:       limit = CNT_W'(1);
            RPT_TEN:        limit = CNT_W'(REP_A);
            RPT_TWENTYFIVE: limit = CNT_W'(REP_B);
            default:        limit = '0;
        endcase
    end

    assign last = stop_q || stop ||
                  (mode_q != RPT_FOREVER && count == limit - 1'b1);

    genvar gi;
    generate
        for (gi = 0; gi < 8; gi++) begin : g_ones
            assign cw_vec[gi] = 1'b1;
        end
        for (gi = 0; gi < CODE_W; gi++) begin : g_code
            assign cw_vec[9 + gi] = code_q[gi];
        end
    endgenerate
    assign cw_vec[8]        = 1'b0;
    assign cw_vec[WORD_W-1] = 1'b0;

endmodule

// File: rtl/dl_tx_arbiter.sv
module dl_tx_arbiter
    import dl_tx_pkg::*;
#(
    parameter int CODE_W     = 6,
    parameter int OPEN_FLAGS = 27,
    parameter int REP_A      = 10,
    parameter int REP_B      = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              msg_valid,
    input  logic              msg_bit,
    output logic              msg_take,
    input  logic [CODE_W-1:0] cw_code,
    input  logic [1:0]        cw_mode,
    input  logic              cw_start,
    input  logic              cw_stop,
    output logic              dl_bit,
    output logic              cw_done
);

    localparam int WORD_W = CODE_W + 10;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int BYTE_W = $clog2(OPEN_FLAGS + 1);
    localparam logic [IDX_W-1:0]  LAST_FLAG_BIT = IDX_W'(7);
    localparam logic [IDX_W-1:0]  LAST_WORD_BIT = IDX_W'(WORD_W - 1);
    localparam logic [BYTE_W-1:0] LAST_OPEN     = BYTE_W'(OPEN_FLAGS - 1);

    dl_state_t          state, state_n;
    logic [IDX_W-1:0]   bit_idx, bit_idx_n;
    logic [BYTE_W-1:0]  byte_cnt, byte_cnt_n;
    logic               word_end;
    logic               cw_active;
    logic               cw_last;
    logic [WORD_W-1:0]  cw_vec;

    dl_cw_ctrl #(
        .CODE_W (CODE_W),
        .REP_A  (REP_A),
        .REP_B  (REP_B)
    ) u_cw (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cw_start),
        .stop     (cw_stop),
        .mode     (cw_mode),
        .code     (cw_code),
        .word_end (word_end),
        .active   (cw_active),
        .last     (cw_last),
        .done     (cw_done),
        .cw_vec   (cw_vec)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_idx  <= '0;
            byte_cnt <= '0;
        end else begin
            state    <= state_n;
            bit_idx  <= bit_idx_n;
            byte_cnt <= byte_cnt_n;
        end
    end

    // Next state, advanced only on a bit strobe
    always_comb begin
        state_n    = state;
        bit_idx_n  = bit_idx;
        byte_cnt_n = byte_cnt;
        word_end   = 1'b0;
        if (bit_en) begin
            unique case (state)
                ST_IDLE: begin
                    if (bit_idx == LAST_FLAG_BIT) begin
                        bit_idx_n = '0;
                        if (msg_valid) begin
                            state_n    = ST_OPEN;
                            byte_cnt_n = '0;
                        end else if (cw_active) begin
                            state_n = ST_CW;
                        end
                    end else begin
                        bit_idx_n = bit_idx + 1'b1;
                    end
                end
                ST_OPEN: begin
                    if (bit_idx == LAST_FLAG_BIT) begin
                        bit_idx_n = '0;
                        if (byte_cnt == LAST_OPEN) begin
                            state_n = ST_MSG;
                        end else begin
                            byte_cnt_n = byte_cnt + 1'b1;
                        end
                    end else begin
                        bit_idx_n = bit_idx + 1'b1;
                    end
                end
                ST_MSG: begin
                    if (!msg_valid) begin
                        state_n   = ST_CLOSE;
                        bit_idx_n = IDX_W'(1);
                    end
                end
                ST_CLOSE: begin
                    if (bit_idx == LAST_FLAG_BIT) begin
                        bit_idx_n = '0;
                        state_n   = ST_IDLE;
                    end else begin
                        bit_idx_n = bit_idx + 1'b1;
                    end
                end
                ST_CW: begin
                    if (bit_idx == LAST_WORD_BIT) begin
                        bit_idx_n = '0;
                        word_end  = 1'b1;
                        if (cw_last) begin
                            state_n = ST_IDLE;
                        end else if (msg_valid) begin
                            state_n    = ST_OPEN;
                            byte_cnt_n = '0;
                        end
                    end else begin
                        bit_idx_n = bit_idx + 1'b1;
                    end
                end
                default: begin
                    state_n   = ST_IDLE;
                    bit_idx_n = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        msg_take = 1'b0;
        unique case (state)
            ST_MSG: begin
                msg_take = msg_valid;
                dl_bit   = msg_valid ? msg_bit : FLAG_BYTE[0];
            end
            ST_CW:   dl_bit = cw_vec[bit_idx];
            default: dl_bit = FLAG_BYTE[bit_idx[2:0]];
        endcase
    end

endmodule

// File: rtl/dl_tx_arbiter_chk.sv
module dl_tx_arbiter_chk
    import dl_tx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      bit_en,
    input logic      msg_valid,
    input logic      msg_take,
    input logic      cw_done,
    input logic      cw_last,
    input logic      word_end,
    input dl_state_t state,
    input logic [3:0] bit_idx
);

    // R3: a frame bit is taken only while the controller says a frame is valid
    assert_take_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_take |-> (msg_valid && state == ST_MSG));

    // R11: no movement between bit strobes
    assert_hold_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(state));

    // R6: code words are entered only from idle (or continue)
    assert_cw_from_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && state == ST_IDLE && msg_valid) |=> state != ST_CW);

    // R7: a word that has begun is not cut short by a pending frame
    assert_word_complete_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CW && bit_idx != 4'd15) |=> state == ST_CW);

    // R9: the done pulse follows the last word and lasts one clock
    assert_done_after_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && cw_last) |=> cw_done);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cw_done |=> !cw_done);

endmodule

bind dl_tx_arbiter dl_tx_arbiter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .msg_valid (msg_valid),
    .msg_take  (msg_take),
    .cw_done   (cw_done),
    .cw_last   (cw_last),
    .word_end  (word_end),
    .state     (state),
    .bit_idx   (bit_idx)
);

// File: tb/sim_dl_tx_arbiter.sv
`timescale 1ns/1ps
module sim_dl_tx_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       msg_valid = 1'b0;
    logic       msg_bit = 1'b0;
    logic       msg_take;
    logic [5:0] cw_code = '0;
    logic [1:0] cw_mode = '0;
    logic       cw_start = 1'b0;
    logic       cw_stop = 1'b0;
    logic       dl_bit;
    logic       cw_done;

    int checks = 0;
    int errors = 0;
    int obs_n = 0;
    int exp_n = 0;
    int done_n = 0;
    int done_at = -1;
    int takes = 0;
    logic obs [0:4095];
    logic expv [0:4095];

    always #10 clk = ~clk;

    dl_tx_arbiter u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .msg_valid (msg_valid),
        .msg_bit   (msg_bit),
        .msg_take  (msg_take),
        .cw_code   (cw_code),
        .cw_mode   (cw_mode),
        .cw_start  (cw_start),
        .cw_stop   (cw_stop),
        .dl_bit    (dl_bit),
        .cw_done   (cw_done)
    );

    // Bit strobe: one clock in six, restarted by reset
    initial begin
        int cnt = 0;
        forever begin
            @(posedge clk);
            #1;
            if (!rst_n) begin
                cnt = 0;
                bit_en = 1'b0;
            end else begin
                cnt = (cnt == 5) ? 0 : cnt + 1;
                bit_en = (cnt == 5);
            end
        end
    end

    // Capture of the line and of done pulses
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && bit_en) begin
                if (obs_n < 4096) obs[obs_n] = dl_bit;
                obs_n++;
            end
            if (rst_n && cw_done) begin
                done_n++;
                done_at = obs_n;
            end
        end
    end

    task automatic check(input string req, input int act, input int expd, input string what);
        checks++;
        if (act != expd) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expd);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        msg_valid = 1'b0;
        msg_bit = 1'b0;
        cw_start = 1'b0;
        cw_stop = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        obs_n = 0;
        exp_n = 0;
        done_n = 0;
        done_at = -1;
        takes = 0;
    endtask

    task automatic push_flags(input int n);
        for (int b = 0; b < n; b++) begin
            for (int i = 0; i < 8; i++) begin
                expv[exp_n] = (i != 0 && i != 7);
                exp_n++;
            end
        end
    endtask

    task automatic push_word(input logic [5:0] code);
        for (int i = 0; i < 8; i++) begin expv[exp_n] = 1'b1; exp_n++; end
        expv[exp_n] = 1'b0; exp_n++;
        for (int i = 0; i < 6; i++) begin expv[exp_n] = code[i]; exp_n++; end
        expv[exp_n] = 1'b0; exp_n++;
    endtask

    task automatic push_msg(input int len, input logic [63:0] pat);
        for (int i = 0; i < len; i++) begin expv[exp_n] = pat[i]; exp_n++; end
    endtask

    task automatic cmp_stream(input string req, input string what);
        int bad = -1;
        wait (obs_n >= exp_n);
        for (int i = 0; i < exp_n; i++) begin
            if (bad < 0 && obs[i] !== expv[i]) bad = i;
        end
        checks++;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s %s: bit %0d actual=%0b expected=%0b", req, what, bad, obs[bad], expv[bad]);
        end
    endtask

    task automatic send_msg(input int len, input logic [63:0] pat);
        int idx = 0;
        msg_bit = pat[0];
        msg_valid = 1'b1;
        while (idx < len) begin
            @(negedge clk);
            if (bit_en && msg_take) begin
                @(posedge clk);
                #1;
                idx++;
                takes++;
                if (idx < len) msg_bit = pat[idx];
                else begin
                    msg_valid = 1'b0;
                    msg_bit = 1'b0;
                end
            end
        end
    endtask

    task automatic pulse_start(input logic [5:0] code, input logic [1:0] mode);
        cw_code = code;
        cw_mode = mode;
        cw_start = 1'b1;
        @(negedge clk);
        cw_start = 1'b0;
    endtask

    task automatic pulse_stop();
        cw_stop = 1'b1;
        @(negedge clk);
        cw_stop = 1'b0;
    endtask

    task automatic t_reset_idle();
        do_reset();
        check("R11", dl_bit, 0, "dl_bit after reset");
        check("R11", msg_take, 0, "msg_take after reset");
        check("R11", cw_done, 0, "cw_done after reset");
        push_flags(4);
        cmp_stream("R1", "idle flags");
    endtask

    task automatic t_message();
        logic [63:0] pat = 64'h0000_0000_000B_3A5C;
        do_reset();
        push_flags(1 + 27);
        push_msg(20, pat);
        push_flags(2);
        send_msg(20, pat);
        cmp_stream("R2", "framed message");
        check("R3", takes, 20, "bits taken");
    endtask

    task automatic t_single();
        do_reset();
        pulse_start(6'b101101, 2'd0);
        push_flags(1);
        push_word(6'b101101);
        push_flags(2);
        cmp_stream("R4", "single code word");
        check("R9", done_n, 1, "done count single");
        check("R9", done_at, 24, "done position single");
    endtask

    task automatic t_ten_ignore();
        do_reset();
        pulse_start(6'b000111, 2'd1);
        wait (obs_n >= 30);
        pulse_start(6'b111000, 2'd0);   // R10: must be ignored
        push_flags(1);
        for (int w = 0; w < 10; w++) push_word(6'b000111);
        push_flags(1);
        cmp_stream("R10", "ten words, restart ignored");
        check("R5", done_n, 1, "done count ten");
        check("R5", done_at, 8 + 160, "done position ten");
    endtask

    task automatic t_twentyfive();
        do_reset();
        pulse_start(6'b010011, 2'd2);
        push_flags(1);
        for (int w = 0; w < 25; w++) push_word(6'b010011);
        push_flags(1);
        cmp_stream("R5", "twenty-five words");
        check("R9", done_at, 8 + 400, "done position twenty-five");
    endtask

    task automatic t_cont_stop();
        do_reset();
        pulse_start(6'b110010, 2'd3);
        wait (obs_n >= 8 + 48 + 5);
        pulse_stop();
        push_flags(1);
        for (int w = 0; w < 4; w++) push_word(6'b110010);
        push_flags(2);
        cmp_stream("R8", "continuous stopped after fourth word");
        check("R8", done_n, 1, "done count after stop");
    endtask

    task automatic t_priority();
        logic [63:0] pat = 64'h0000_0000_0000_0C96;
        do_reset();
        pulse_start(6'b001001, 2'd1);
        push_flags(1 + 27);
        push_msg(12, pat);
        push_flags(2);
        push_word(6'b001001);
        send_msg(12, pat);
        cmp_stream("R6", "frame ahead of code word");
    endtask

    task automatic t_preempt();
        logic [63:0] pat = 64'h0000_0000_0000_0A3F;
        int resume;
        do_reset();
        pulse_start(6'b100110, 2'd3);
        wait (obs_n >= 13);
        push_flags(1);
        push_word(6'b100110);
        push_flags(27);
        push_msg(12, pat);
        push_flags(2);
        resume = exp_n;
        push_word(6'b100110);
        push_flags(1);
        fork
            send_msg(12, pat);
        join_none
        wait (obs_n >= resume + 3);
        pulse_stop();
        cmp_stream("R7", "word completes, frame pre-empts, sequence resumes");
        check("R7", done_at, resume + 16, "done after resumed word");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_idle();
        t_message();
        t_single();
        t_ten_ignore();
        t_twentyfive();
        t_cont_stop();
        t_priority();
        t_preempt();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule